// File: doc/BRIEF.md
# Dashed Bresenham Line Engine

This block draws one straight line of 8-bit pixels into a frame buffer held in an external synchronous memory. A trigger supplies two endpoints, each packed as X in bits 31:16 and Y in bits 15:0. The engine folds the line into a single stepping direction by exchanging axes and endpoints. It then walks the major axis one pixel per clock and drives the minor axis from an integer error term. Each visited pixel can be written through a masked raster operation. The engine reads the old byte, combines it with the line colour under a plane mask, and writes the result back one clock later.

Dashed lines are drawn as a run of segments over the same geometry. The first segment opens a window: it plots a given number of pixels and records that length. Each later segment skips the pixels already covered and plots the next run. It also flips the colour select, so the dashes alternate between foreground and background colours. A plain line can instead take an explicit skip count and pixel limit. A plain line also reports its end point on the `endpt_o` output, where it can serve as the start of the next line.

Top module: `lp_line_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `sel_o`, `mem_rd_en_o` and `mem_we_o` are 0 and `endpt_o` is 0.
- R2: A line is culled when both endpoint X values are at or beyond W, or both endpoint Y values are at or beyond H. A culled line makes no memory access, and `done_o` is raised in the first cycle after the trigger.
- R3: Pixels follow the normalised Bresenham walk, one step per clock.
  - If |dy| > |dx|, the axes are exchanged. If the first major coordinate then exceeds the second, the endpoints are exchanged.
  - The error starts at 2·dmin − dmaj. A positive error steps the minor axis toward the end, by −1 when the start minor coordinate is greater than the end one and by +1 otherwise, and adds 2·(dmin − dmaj). Otherwise the error adds 2·dmin.
  - A pixel at (px, py) has offset py·W + px. Offsets at or above W·H are not accessed.
- R4: The skip count stops the write of the first N stepped pixels. Each skipped pixel still takes one clock and one step.
- R5: A limit of all ones (−1) is unlimited. Otherwise stepping ends after the step that takes the pre-decremented limit to zero or below, so a limit of M ≥ 1 gives at most M steps and a limit of 0 gives one step. Stepping always ends once the major coordinate passes its end.
- R6: The line colour is `fg_i` when the colour select is 1 and `bg_i` when it is 0. Modes 0, 1 and 3 load the select from `fgsel_i`.
- R7: With op code o, old byte d, colour c and mask m, the written value is:
  - o=0: d&~m
  - o=3: (d&~m)|(c&m)
  - o=6: d^(c&m)
  - o=10: d^m
  - o=15: d|m
  - any other code: no write.
- R8: `mode_i` selects the kind of trigger.
  - 0 and 3 are plain lines.
  - 1 opens a dash: skip 0, limit `seg_len_i`, and the stored run length becomes `seg_len_i`.
  - 2 continues a dash: skip is the stored length, limit is stored + `seg_len_i`, and the stored length grows by `seg_len_i`. The segment uses the current select, which then toggles. Both updates happen even when the segment is culled.
- R9: A plain, non-culled trigger sets `endpt_o` to `pb_i`. `endpt_o` changes at no other time.
- R10: `busy_o` is high from the cycle after the trigger through the cycle of `done_o`. `done_o` lasts one cycle. A trigger while busy is ignored.
- R11: Each write goes to the address read one cycle earlier, and it uses the byte returned by that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Trigger, accepted when idle |
| mode_i | input | 2 | Trigger kind (plain, dash open, dash continue) |
| pa_i | input | 32 | First endpoint, X in 31:16, Y in 15:0 |
| pb_i | input | 32 | Second endpoint, same packing |
| skip_i | input | CNT_W | Skip count for plain lines |
| limit_i | input | CNT_W | Pixel limit for plain lines, all ones for unlimited |
| seg_len_i | input | CNT_W | Dash segment length |
| fgsel_i | input | 1 | Colour select loaded by modes 0, 1 and 3 |
| fg_i | input | 8 | Foreground colour |
| bg_i | input | 8 | Background colour |
| rop_i | input | 4 | Raster op code |
| pmask_i | input | 8 | Plane mask |
| busy_o | output | 1 | Engine active |
| done_o | output | 1 | One-cycle completion pulse |
| sel_o | output | 1 | Current colour select |
| endpt_o | output | 32 | End point of the last plain line |
| mem_rd_en_o | output | 1 | Frame buffer read request |
| mem_rd_addr_o | output | ADDR_W | Read address |
| mem_rd_data_i | input | 8 | Read data, one cycle after the request |
| mem_we_o | output | 1 | Frame buffer write enable |
| mem_wr_addr_o | output | ADDR_W | Write address |
| mem_wr_data_o | output | 8 | Write data |

## Verification
The bench drives lines in every octant class. These include steep lines with reversed endpoints and shallow lines whose Y falls along the walk. An error in axis exchange or endpoint ordering would put pixels on the wrong row or walk the line backwards. Skip counts, a limit of 0, a limit of 5 and the unlimited limit all run against a behavioural walk, so an off-by-one in the pre-decrement would show up as one pixel too many or too few. Dash runs include a culled continuation, to check that the stored length and the colour toggle still advance. The bench also tests all five op codes plus one unsupported code, a line partly below the buffer, and a trigger raised mid-line. A design that got any of these wrong would write extra bytes, drop bytes or restart the line.

// File: rtl/lp_pkg.sv
package lp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } lp_state_e;

    localparam logic [1:0] MODE_PLAIN     = 2'd0;
    localparam logic [1:0] MODE_DASH_OPEN = 2'd1;
    localparam logic [1:0] MODE_DASH_NEXT = 2'd2;

    localparam int ERR_W = 19;

endpackage

// File: rtl/lp_normalise.sv
module lp_normalise #(
    parameter int W = 64,
    parameter int H = 32,
    parameter int ERR_W = 19
) (
    input  logic [31:0]             pa_i,
    input  logic [31:0]             pb_i,
    output logic                    cull_o,
    output logic                    steep_o,
    output logic                    minor_dec_o,
    output logic [16:0]             maj_start_o,
    output logic [16:0]             maj_end_o,
    output logic [15:0]             min_start_o,
    output logic signed [ERR_W-1:0] err_o,
    output logic signed [ERR_W-1:0] flat_o,
    output logic signed [ERR_W-1:0] diag_o
);
    logic [15:0] ax, ay, bx, by, dx, dy, dmaj, dmin;
    logic [15:0] u1, v1, u2, v2;
    logic        order_swap;

    always_comb begin
        ax = pa_i[31:16];
        ay = pa_i[15:0];
        bx = pb_i[31:16];
        by = pb_i[15:0];
        cull_o = ((32'(ax) >= W) && (32'(bx) >= W)) ||
                 ((32'(ay) >= H) && (32'(by) >= H));
        dx = (ax > bx) ? (ax - bx) : (bx - ax);
        dy = (ay > by) ? (ay - by) : (by - ay);
        steep_o = dy > dx;
        u1   = steep_o ? ay : ax;
        v1   = steep_o ? ax : ay;
        u2   = steep_o ? by : bx;
        v2   = steep_o ? bx : by;
        dmaj = steep_o ? dy : dx;
        dmin = steep_o ? dx : dy;
        order_swap  = u1 > u2;
        maj_start_o = {1'b0, order_swap ? u2 : u1};
        maj_end_o   = {1'b0, order_swap ? u1 : u2};
        min_start_o = order_swap ? v2 : v1;
        minor_dec_o = order_swap ? (v2 > v1) : (v1 > v2);
        flat_o = $signed({2'b00, dmin, 1'b0});
        diag_o = $signed({2'b00, dmin, 1'b0}) - $signed({2'b00, dmaj, 1'b0});
        err_o  = $signed({2'b00, dmin, 1'b0}) - $signed({3'b000, dmaj});
    end
endmodule

// File: rtl/lp_rop.sv
module lp_rop (
    input  logic [3:0] op_i,
    input  logic [7:0] dst_i,
    input  logic [7:0] src_i,
    input  logic [7:0] mask_i,
    output logic [7:0] res_o,
    output logic       wr_ok_o
);
    always_comb begin
        wr_ok_o = 1'b1;
        case (op_i)
            4'd0:    res_o = dst_i & ~mask_i;
            4'd3:    res_o = (dst_i & ~mask_i) | (src_i & mask_i);
            4'd6:    res_o = dst_i ^ (src_i & mask_i);
            4'd10:   res_o = dst_i ^ mask_i;
            4'd15:   res_o = dst_i | mask_i;
            default: begin
                res_o   = dst_i;
                wr_ok_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lp_line_engine.sv
module lp_line_engine
    import lp_pkg::*;
#(
    parameter int W = 64,
    parameter int H = 32,
    parameter int CNT_W = 16,
    localparam int ADDR_W = $clog2(W * H)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [31:0]       pa_i,
    input  logic [31:0]       pb_i,
    input  logic [CNT_W-1:0]  skip_i,
    input  logic [CNT_W-1:0]  limit_i,
    input  logic [CNT_W-1:0]  seg_len_i,
    input  logic              fgsel_i,
    input  logic [7:0]        fg_i,
    input  logic [7:0]        bg_i,
    input  logic [3:0]        rop_i,
    input  logic [7:0]        pmask_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              sel_o,
    output logic [31:0]       endpt_o,
    output logic              mem_rd_en_o,
    output logic [ADDR_W-1:0] mem_rd_addr_o,
    input  logic [7:0]        mem_rd_data_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_wr_addr_o,
    output logic [7:0]        mem_wr_data_o
);
    localparam int LIM_W = CNT_W + 2;
    localparam logic [33:0] PIX = 34'(W * H);

    typedef struct packed {
        lp_state_e               st;
        logic [16:0]             maj;
        logic [16:0]             maj_end;
        logic [15:0]             mnr;
        logic                    mnr_dec;
        logic                    steep;
        logic signed [ERR_W-1:0] err;
        logic signed [ERR_W-1:0] flat;
        logic signed [ERR_W-1:0] diag;
        logic [CNT_W:0]          skip;
        logic [LIM_W-1:0]        rem;
        logic                    unlim;
        logic [7:0]              colour;
        logic [3:0]              rop;
        logic [7:0]              pmask;
        logic                    pend;
        logic [ADDR_W-1:0]       paddr;
        logic                    sel;
        logic [CNT_W-1:0]        acc;
        logic [31:0]             endpt;
    } eng_t;

    eng_t q, d;

    logic                    n_cull, n_steep, n_dec;
    logic [16:0]             n_maj, n_maj_end;
    logic [15:0]             n_mnr;
    logic signed [ERR_W-1:0] n_err, n_flat, n_diag;
    logic [7:0]              rop_res;
    logic                    rop_ok;

    lp_normalise #(.W(W), .H(H), .ERR_W(ERR_W)) u_norm (
        .pa_i(pa_i), .pb_i(pb_i), .cull_o(n_cull), .steep_o(n_steep),
        .minor_dec_o(n_dec), .maj_start_o(n_maj), .maj_end_o(n_maj_end),
        .min_start_o(n_mnr), .err_o(n_err), .flat_o(n_flat), .diag_o(n_diag)
    );

    lp_rop u_rop (
        .op_i(q.rop), .dst_i(mem_rd_data_i), .src_i(q.colour),
        .mask_i(q.pmask), .res_o(rop_res), .wr_ok_o(rop_ok)
    );

    logic [16:0]      pix_x, pix_y;
    logic [33:0]      ofs;
    logic             plot;
    logic [LIM_W-1:0] rem_m1;
    logic             keep_going;
    logic [CNT_W:0]   acc_sum;

    always_comb begin
        d           = q;
        d.pend      = 1'b0;
        done_o      = 1'b0;
        mem_rd_en_o = 1'b0;
        pix_x       = q.steep ? {1'b0, q.mnr} : q.maj;
        pix_y       = q.steep ? q.maj : {1'b0, q.mnr};
        ofs         = 34'(pix_y) * 34'(W) + 34'(pix_x);
        plot        = 1'b0;
        rem_m1      = q.rem - {{(LIM_W-1){1'b0}}, 1'b1};
        keep_going  = 1'b0;
        acc_sum     = {1'b0, q.acc} + {1'b0, seg_len_i};
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.maj     = n_maj;
                    d.maj_end = n_maj_end;
                    d.mnr     = n_mnr;
                    d.mnr_dec = n_dec;
                    d.steep   = n_steep;
                    d.err     = n_err;
                    d.flat    = n_flat;
                    d.diag    = n_diag;
                    d.rop     = rop_i;
                    d.pmask   = pmask_i;
                    d.colour  = fgsel_i ? fg_i : bg_i;
                    d.sel     = fgsel_i;
                    d.unlim   = 1'b0;
                    case (mode_i)
                        MODE_DASH_OPEN: begin
                            d.skip = '0;
                            d.rem  = {2'b00, seg_len_i};
                            d.acc  = seg_len_i;
                        end
                        MODE_DASH_NEXT: begin
                            d.colour = q.sel ? fg_i : bg_i;
                            d.sel    = ~q.sel;
                            d.skip   = {1'b0, q.acc};
                            d.rem    = {1'b0, acc_sum};
                            d.acc    = acc_sum[CNT_W-1:0];
                        end
                        default: begin
                            d.skip  = {1'b0, skip_i};
                            d.rem   = {{2{limit_i[CNT_W-1]}}, limit_i};
                            d.unlim = &limit_i;
                            if (!n_cull) begin
                                d.endpt = pb_i;
                            end
                        end
                    endcase
                    d.st = n_cull ? ST_FLUSH : ST_RUN;
                end
            end
            ST_RUN: begin
                if (q.skip != '0) begin
                    d.skip = q.skip - 1'b1;
                end else begin
                    plot = ofs < PIX;
                end
                mem_rd_en_o = plot;
                d.pend      = plot;
                d.paddr     = ofs[ADDR_W-1:0];
                if (!q.err[ERR_W-1] && (q.err != '0)) begin
                    d.mnr = q.mnr_dec ? (q.mnr - 1'b1) : (q.mnr + 1'b1);
                    d.err = q.err + q.diag;
                end else begin
                    d.err = q.err + q.flat;
                end
                d.maj = q.maj + 1'b1;
                d.rem = rem_m1;
                keep_going = ((q.maj + 1'b1) <= q.maj_end) &&
                             (q.unlim || (!rem_m1[LIM_W-1] && (rem_m1 != '0)));
                if (!keep_going) begin
                    d.st = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                done_o = 1'b1;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign mem_rd_addr_o = ofs[ADDR_W-1:0];
    assign mem_we_o      = q.pend && rop_ok;
    assign mem_wr_addr_o = q.paddr;
    assign mem_wr_data_o = rop_res;
    assign busy_o        = q.st != ST_IDLE;
    assign sel_o         = q.sel;
    assign endpt_o       = q.endpt;
endmodule

// File: rtl/lp_line_engine_chk.sv
module lp_line_engine_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [31:0]       endpt_o,
    input logic              mem_rd_en_o,
    input logic [ADDR_W-1:0] mem_rd_addr_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_wr_addr_o
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R10
    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> busy_o); // R10
    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && !done_o) |=> busy_o); // R10
    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> !(mem_rd_en_o || mem_we_o)); // R10
    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) mem_we_o |-> ($past(mem_rd_en_o) && (mem_wr_addr_o == $past(mem_rd_addr_o)))); // R11
    AST_ENDPT_ONLY_ON_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n) (busy_o || !start_i) |=> $stable(endpt_o)); // R9
endmodule

bind lp_line_engine lp_line_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .endpt_o(endpt_o), .mem_rd_en_o(mem_rd_en_o),
    .mem_rd_addr_o(mem_rd_addr_o), .mem_we_o(mem_we_o),
    .mem_wr_addr_o(mem_wr_addr_o)
);

// File: tb/lp_line_engine_test.sv
`timescale 1ns/1ps
module lp_line_engine_test;
    localparam int W = 64;
    localparam int H = 32;
    localparam int PIX = W * H;
    localparam int CW = 16;
    localparam int AW = $clog2(PIX);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [1:0] mode_i = '0;
    logic [31:0] pa_i = '0, pb_i = '0;
    logic [CW-1:0] skip_i = '0, limit_i = '0, seg_len_i = '0;
    logic fgsel_i = 1'b0;
    logic [7:0] fg_i = 8'hA5, bg_i = 8'h3C;
    logic [3:0] rop_i = '0;
    logic [7:0] pmask_i = '0;
    logic busy_o, done_o, sel_o;
    logic [31:0] endpt_o;
    logic mem_rd_en_o, mem_we_o;
    logic [AW-1:0] mem_rd_addr_o, mem_wr_addr_o;
    logic [7:0] mem_rd_data_i = '0, mem_wr_data_o;

    always #2.5 clk = ~clk;

    lp_line_engine #(.W(W), .H(H), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .pa_i(pa_i), .pb_i(pb_i), .skip_i(skip_i), .limit_i(limit_i),
        .seg_len_i(seg_len_i), .fgsel_i(fgsel_i), .fg_i(fg_i), .bg_i(bg_i),
        .rop_i(rop_i), .pmask_i(pmask_i), .busy_o(busy_o), .done_o(done_o),
        .sel_o(sel_o), .endpt_o(endpt_o), .mem_rd_en_o(mem_rd_en_o),
        .mem_rd_addr_o(mem_rd_addr_o), .mem_rd_data_i(mem_rd_data_i),
        .mem_we_o(mem_we_o), .mem_wr_addr_o(mem_wr_addr_o),
        .mem_wr_data_o(mem_wr_data_o)
    );

    logic [7:0] fb [PIX];
    logic [7:0] ref_fb [PIX];

    always @(posedge clk) begin
        if (mem_rd_en_o) mem_rd_data_i <= fb[mem_rd_addr_o];
        if (mem_we_o) fb[mem_wr_addr_o] <= mem_wr_data_o;
    end

    int checks = 0;
    int fails = 0;

    int m_acc = 0;
    bit m_sel = 1'b0;
    logic [31:0] m_endpt = '0;
    bit e_we[$];
    int e_addr[$];
    logic [7:0] e_data[$];
    int n_steps;

    task automatic check(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    function automatic logic [7:0] ref_rop(input int op, input logic [7:0] dv,
                                           input logic [7:0] sv, input logic [7:0] mv,
                                           output bit ok);
        ok = 1'b1;
        case (op)
            0:  return dv & ~mv;
            3:  return (dv & ~mv) | (sv & mv);
            6:  return dv ^ (sv & mv);
            10: return dv ^ mv;
            15: return dv | mv;
            default: begin ok = 1'b0; return dv; end
        endcase
    endfunction

    // behavioural walk: fills the per-step expectations and updates ref_fb
    task automatic model_line(input int mode, input logic [31:0] pa, input logic [31:0] pb,
                              input int skip_in, input int lim_in, input int len,
                              input bit fgsel, input int op, input int pm);
        int x1, y1, x2, y2, dx, dy, t, e, x, y, incy, ofs, skp, mx;
        bit c1, cull, pl, ok, cont;
        logic [7:0] col, dv;
        e_we.delete(); e_addr.delete(); e_data.delete();
        x1 = pa[31:16]; y1 = pa[15:0]; x2 = pb[31:16]; y2 = pb[15:0];
        cull = (x1 >= W && x2 >= W) || (y1 >= H && y2 >= H);
        if (mode == 2) begin
            col = m_sel ? fg_i : bg_i;
            skp = m_acc; mx = m_acc + len;
            m_acc = m_acc + len; m_sel = ~m_sel;
        end else if (mode == 1) begin
            col = fgsel ? fg_i : bg_i;
            skp = 0; mx = len; m_acc = len; m_sel = fgsel;
        end else begin
            col = fgsel ? fg_i : bg_i;
            skp = skip_in; mx = lim_in; m_sel = fgsel;
            if (!cull) m_endpt = pb;
        end
        n_steps = 0;
        if (cull) return;
        dx = (x2 > x1) ? x2 - x1 : x1 - x2;
        dy = (y2 > y1) ? y2 - y1 : y1 - y2;
        c1 = 1'b0;
        if (dy > dx) begin
            t = y2; y2 = x2; x2 = t;
            t = y1; y1 = x1; x1 = t;
            t = dx; dx = dy; dy = t;
            c1 = 1'b1;
        end
        if (x1 > x2) begin
            t = y2; y2 = y1; y1 = t;
            t = x1; x1 = x2; x2 = t;
        end
        e = 2 * dy - dx;
        incy = (y1 <= y2) ? 1 : -1;
        x = x1; y = y1;
        while (1) begin
            ofs = c1 ? x * W + y : y * W + x;
            pl = 1'b0; ok = 1'b0; dv = '0;
            if (skp > 0) skp--;
            else if (ofs < PIX) pl = 1'b1;
            if (pl) begin
                dv = ref_rop(op, ref_fb[ofs], col, 8'(pm), ok);
                if (ok) ref_fb[ofs] = dv;
            end
            e_we.push_back(pl && ok);
            e_addr.push_back(ofs);
            e_data.push_back(dv);
            if (e > 0) begin y += incy; e += 2 * (dy - dx); end
            else e += 2 * dy;
            x++;
            n_steps++;
            cont = 1'b0;
            if (x <= x2) begin
                if (mx == -1) cont = 1'b1;
                else begin mx--; cont = mx > 0; end
            end
            if (!cont) break;
        end
    endtask

    task automatic run_line(input string tag, input int mode, input logic [31:0] pa,
                            input logic [31:0] pb, input int skip_in, input int lim_in,
                            input int len, input bit fgsel, input int op, input int pm,
                            input bit poke);
        bit xwe;
        model_line(mode, pa, pb, skip_in, lim_in, len, fgsel, op, pm);
        @(negedge clk);
        mode_i = 2'(mode); pa_i = pa; pb_i = pb; skip_i = CW'(skip_in);
        limit_i = CW'(lim_in); seg_len_i = CW'(len); fgsel_i = fgsel;
        rop_i = 4'(op); pmask_i = 8'(pm); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c <= n_steps; c++) begin
            if (c > 0) @(negedge clk);
            xwe = (c > 0) ? e_we[c-1] : 1'b0;
            check(busy_o === 1'b1 && done_o === (c == n_steps) && mem_we_o === xwe &&
                  (!xwe || (mem_wr_addr_o == AW'(e_addr[c-1]) && mem_wr_data_o == e_data[c-1])),
                  tag, $sformatf("cycle %0d got busy=%0b done=%0b we=%0b addr=%0d data=%02h, expected busy=1 done=%0b we=%0b addr=%0d data=%02h",
                  c, busy_o, done_o, mem_we_o, mem_wr_addr_o, mem_wr_data_o,
                  (c == n_steps), xwe, (c > 0) ? e_addr[c-1] : 0, (c > 0) ? e_data[c-1] : 8'h00));
            if (poke && c == 1) begin
                start_i = 1'b1; pa_i = 32'h0003_0001; pb_i = 32'h0030_0010; mode_i = 2'd0;
            end
            if (poke && c == 2) start_i = 1'b0;
        end
        @(negedge clk);
        check(busy_o === 1'b0 && done_o === 1'b0 && mem_we_o === 1'b0, tag,
              $sformatf("after done got busy=%0b done=%0b we=%0b, expected 0 0 0", busy_o, done_o, mem_we_o));
        check(sel_o === m_sel, {tag, " R6 R8 select"},
              $sformatf("sel got %0b expected %0b", sel_o, m_sel));
        check(endpt_o === m_endpt, {tag, " R9 endpoint"},
              $sformatf("endpt got %08h expected %08h", endpt_o, m_endpt));
    endtask

    function automatic logic [31:0] xy(input int x, input int y);
        return {16'(x), 16'(y)};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int bad;
        for (int i = 0; i < PIX; i++) begin
            fb[i] = 8'((i * 7) ^ (i >> 3));
            ref_fb[i] = fb[i];
        end
        repeat (3) @(negedge clk);
        check(busy_o === 1'b0 && done_o === 1'b0 && sel_o === 1'b0 && endpt_o === 32'h0 &&
              mem_rd_en_o === 1'b0 && mem_we_o === 1'b0, "R1 reset",
              $sformatf("got busy=%0b done=%0b sel=%0b endpt=%08h rd=%0b we=%0b, expected all 0",
              busy_o, done_o, sel_o, endpt_o, mem_rd_en_o, mem_we_o));
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o === 1'b0 && mem_we_o === 1'b0, "R1 after release",
              $sformatf("got busy=%0b we=%0b expected 0 0", busy_o, mem_we_o));

        // R3 R6 R7 shallow line, foreground copy
        run_line("R3 shallow", 0, xy(0, 0), xy(10, 4), 0, -1, 0, 1, 3, 'hFF, 0);
        // R3 steep with reversed endpoints, background xor
        run_line("R3 steep reversed", 0, xy(8, 20), xy(5, 2), 0, -1, 0, 0, 6, 'hFF, 0);
        // R3 falling minor axis, masked copy; R10 trigger while busy ignored
        run_line("R3 R10 falling poke", 0, xy(20, 3), xy(2, 9), 0, -1, 0, 1, 3, 'h0F, 1);
        // R4 skip
        run_line("R4 skip3", 0, xy(1, 10), xy(30, 12), 3, -1, 0, 1, 3, 'hFF, 0);
        // R5 limits
        run_line("R5 limit5", 0, xy(1, 14), xy(30, 16), 0, 5, 0, 0, 3, 'hFF, 0);
        run_line("R5 limit0", 0, xy(1, 18), xy(30, 18), 0, 0, 0, 1, 3, 'hFF, 0);
        // R2 culling in X and in Y
        run_line("R2 cull x", 0, xy(64, 1), xy(70, 5), 0, -1, 0, 1, 3, 'hFF, 0);
        run_line("R2 cull y", 0, xy(1, 32), xy(5, 40), 0, -1, 0, 0, 3, 'hFF, 0);
        // R3 line partly below the buffer
        run_line("R3 partial", 0, xy(3, 28), xy(9, 40), 0, -1, 0, 1, 3, 'hFF, 0);
        // R7 op codes
        run_line("R7 clear", 0, xy(0, 22), xy(15, 22), 0, -1, 0, 1, 0, 'hF0, 0);
        run_line("R7 set", 0, xy(0, 23), xy(15, 24), 0, -1, 0, 1, 15, 'h0F, 0);
        run_line("R7 invert", 0, xy(0, 25), xy(15, 26), 0, -1, 0, 0, 10, 'hFF, 0);
        run_line("R7 unsupported", 0, xy(0, 27), xy(15, 27), 0, -1, 0, 1, 5, 'hFF, 0);
        // R8 dashed segments
        run_line("R8 dash open", 1, xy(40, 0), xy(60, 10), 0, 0, 4, 1, 3, 'hFF, 0);
        run_line("R8 dash next a", 2, xy(40, 0), xy(60, 10), 0, 0, 3, 0, 3, 'hFF, 0);
        run_line("R8 dash next b", 2, xy(40, 0), xy(60, 10), 0, 0, 5, 0, 3, 'hFF, 0);
        run_line("R8 dash culled", 2, xy(100, 0), xy(110, 0), 0, 0, 2, 0, 3, 'hFF, 0);
        run_line("R8 dash tail", 2, xy(40, 0), xy(60, 10), 0, 0, 100, 0, 3, 'hFF, 0);
        // R9 plain line after dashes moves the endpoint again
        run_line("R9 plain", 3, xy(33, 30), xy(63, 1), 0, -1, 0, 0, 6, 'h3C, 0);

        bad = 0;
        for (int i = 0; i < PIX; i++) if (fb[i] !== ref_fb[i]) bad++;
        check(bad == 0, "R3 R7 R11 image", $sformatf("got %0d mismatching bytes expected 0", bad));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule